// File: doc/BRIEF.md
# Oscillator Calibration Sequencer

This block starts and tracks calibration of an on-chip oscillator from a pair of staged control bits. A host writes a shadow calibrate bit; an update strobe copies the shadow value into the active bit. A calibration is launched only when the active bit moves from 0 to 1. The bit never clears itself, so a further run needs the host to stage and commit a 0 first, then stage and commit a 1. While a run is in progress a busy status reads 1. When the run ends a one-cycle done pulse is issued. The tuning algorithm itself is stood in for by a wait of `CAL_CYCLES` reference clock cycles.

The whole controller runs from the reference oscillator clock. A reference-present input gates the run: no run starts without it, and a run in progress pauses its count while the reference is absent. Settings restored at load time can write both copies of the calibrate bit together. A rise that comes from such a load is held pending until the load-busy input drops. Clock distribution is held in sync from reset until the first calibration has finished and the loop reports lock.

All pins are plain control and status levels or strobes. No data stream crosses the boundary, so there is no flow control.

Top module: `osc_cal_seq`

## Requirements
- R1: After reset, `cal_active`, `cal_busy` and `cal_done` are 0 and `hold_sync` is 1.
- R2: A shadow write (`shadow_we`) has no effect on `cal_active` or `cal_busy` until `upd_stb` is asserted.
- R3: `upd_stb` sampled at a clock edge copies the shadow bit into `cal_active` at that edge. If this takes `cal_active` from 0 to 1 and the reference is present, `cal_busy` reads 1 from the second edge after the strobe.
- R4: `cal_busy` stays 1 for exactly `CAL_CYCLES` clock cycles in which `ref_present` is 1. The default for `CAL_CYCLES` is 1024.
- R5: `cal_active` is not cleared by the end of a calibration.
- R6: Committing 1 while `cal_active` is already 1 does not start a calibration.
- R7: `cal_done` is 1 for exactly one cycle, the first cycle in which `cal_busy` is 0 after a run.
- R8: `hold_sync` is 1 until the first calibration since reset has finished. After that it equals the inverse of `pll_lock`.
- R9: While `ref_present` is 0, a pending calibration does not start and a running one holds its count. Counting resumes when the reference returns.
- R10: `load_wr` writes `load_bit` into both the shadow and the active bit. A 0-to-1 rise caused by a load starts the calibration only after `load_busy` is 0.
- R11: A 0-to-1 rise of `cal_active` during a run is held. It starts a new run one cycle after the current run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shadow_we | input | 1 | Write strobe for the shadow calibrate bit |
| shadow_din | input | 1 | Value written to the shadow bit |
| upd_stb | input | 1 | Update strobe: shadow bit to active bit |
| load_wr | input | 1 | Restore write of both calibrate bits |
| load_bit | input | 1 | Restored calibrate value |
| load_busy | input | 1 | Settings restore in progress; blocks launch |
| ref_present | input | 1 | Reference clock detected |
| pll_lock | input | 1 | Loop lock indication |
| cal_active | output | 1 | Readback of the active calibrate bit |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle pulse at the end of a run |
| hold_sync | output | 1 | Hold distribution in sync |

## Verification
The hardest case to reach from the ports is a new rise of the active bit that arrives during a run. To produce it the bench commits 0 and then commits 1 while `cal_busy` is high, and then expects two back-to-back runs separated by a single idle cycle. Pausing by dropping `ref_present` in the middle of a run is also exercised, and the expected busy length is stretched by the exact number of absent cycles. A scoreboard queue holds the expected busy length of each run and is checked at every done pulse.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } cal_state_e;
endpackage

// File: rtl/cal_bit_stage.sv
// Shadow/active calibrate bit pair with rise detection and pending launch flag.
module cal_bit_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic shadow_we,
  input  logic shadow_din,
  input  logic upd_stb,
  input  logic load_wr,
  input  logic load_bit,
  input  logic launch,
  output logic active,
  output logic pending
);
  logic shadow_q;
  logic active_q;
  logic active_nxt;
  logic rise;

  always_comb begin
    active_nxt = active_q;
    if (load_wr)      active_nxt = load_bit;
    else if (upd_stb) active_nxt = shadow_q;
  end

  assign rise = active_nxt & ~active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= 1'b0;
      active_q <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (load_wr)        shadow_q <= load_bit;
      else if (shadow_we) shadow_q <= shadow_din;
      active_q <= active_nxt;
      // a fresh rise wins over a launch in the same cycle
      pending  <= (pending & ~launch) | rise;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/cal_run_timer.sv
// Fixed-duration calibration run, paused while the reference is absent.
module cal_run_timer #(
  parameter int CAL_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic ref_present,
  input  logic load_busy,
  output logic launch,
  output logic busy,
  output logic done
);
  import osc_cal_pkg::*;
  localparam int CW = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CAL_CYCLES - 1);

  cal_state_e st;
  logic [CW-1:0] cnt;

  assign launch = pending & (st != ST_RUN) & ref_present & ~load_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (ref_present) begin
            if (cnt == LAST) st <= ST_DONE;
            else             cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (launch) begin
            st  <= ST_RUN;
            cnt <= '0;
          end else begin
            st <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy = (st == ST_RUN);
  assign done = (st == ST_DONE);
endmodule

// File: rtl/sync_hold_ctrl.sv
// Holds distribution until the first run has ended and the loop is locked.
module sync_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic pll_lock,
  output logic hold_sync
);
  logic first_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    first_done_q <= 1'b0;
    else if (done) first_done_q <= 1'b1;
  end

  assign hold_sync = ~(first_done_q & pll_lock);
endmodule

// File: rtl/osc_cal_seq.sv
module osc_cal_seq #(
  parameter int CAL_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shadow_we,
  input  logic shadow_din,
  input  logic upd_stb,
  input  logic load_wr,
  input  logic load_bit,
  input  logic load_busy,
  input  logic ref_present,
  input  logic pll_lock,
  output logic cal_active,
  output logic cal_busy,
  output logic cal_done,
  output logic hold_sync
);
  logic launch;
  logic pending;

  cal_bit_stage u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .shadow_we  (shadow_we),
    .shadow_din (shadow_din),
    .upd_stb    (upd_stb),
    .load_wr    (load_wr),
    .load_bit   (load_bit),
    .launch     (launch),
    .active     (cal_active),
    .pending    (pending)
  );

  cal_run_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .pending     (pending),
    .ref_present (ref_present),
    .load_busy   (load_busy),
    .launch      (launch),
    .busy        (cal_busy),
    .done        (cal_done)
  );

  sync_hold_ctrl u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (cal_done),
    .pll_lock  (pll_lock),
    .hold_sync (hold_sync)
  );
endmodule

// File: rtl/osc_cal_seq_chk.sv
module osc_cal_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic upd_stb,
  input logic load_wr,
  input logic ref_present,
  input logic cal_active,
  input logic cal_busy,
  input logic cal_done,
  input logic hold_sync
);
  logic seen_done;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_done <= 1'b0;
    else if (cal_done) seen_done <= 1'b1;
  end

  p_shadow_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_stb && !load_wr) |=> $stable(cal_active));

  p_no_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_active && !upd_stb && !load_wr) |=> cal_active);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done);

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!cal_busy && $past(cal_busy)));

  p_hold_until_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_done |-> hold_sync);

  p_pause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !ref_present) |=> cal_busy);
endmodule

bind osc_cal_seq osc_cal_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_stb     (upd_stb),
  .load_wr     (load_wr),
  .ref_present (ref_present),
  .cal_active  (cal_active),
  .cal_busy    (cal_busy),
  .cal_done    (cal_done),
  .hold_sync   (hold_sync)
);

// File: tb/osc_cal_seq_tb.sv
module osc_cal_seq_tb;
  localparam int CAL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shadow_we = 0, shadow_din = 0, upd_stb = 0;
  logic load_wr = 0, load_bit = 0, load_busy = 0;
  logic ref_present = 1, pll_lock = 0;
  logic cal_active, cal_busy, cal_done, hold_sync;

  int n_chk = 0, n_fail = 0, cyc = 0, run_len = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  osc_cal_seq #(.CAL_CYCLES(CAL)) u_dut (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stage(logic v);
    shadow_we = 1; shadow_din = v; tick(1); shadow_we = 0;
  endtask

  task automatic commit();
    upd_stb = 1; tick(1); upd_stb = 0;
  endtask

  task automatic wait_done();
    while (!cal_done) tick(1);
    tick(1);
  endtask

  // scoreboard monitor: busy length per run
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) run_len = 0;
    else begin
      if (cal_busy) run_len++;
      if (cal_done) begin
        if (exp_q.size() == 0) check("R4 unexpected run", run_len, -1);
        else check("R4 busy length", run_len, exp_q.pop_front());
        run_len = 0;
      end
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R1 active", cal_active, 0);
    check("R1 busy", cal_busy, 0);
    check("R1 done", cal_done, 0);
    check("R1 hold", hold_sync, 1);
    rst_n = 1; tick(2);

    // R2: staged write alone does nothing
    stage(1); tick(4);
    check("R2 active", cal_active, 0);
    check("R2 busy", cal_busy, 0);

    // R3: commit starts run at second edge
    exp_q.push_back(CAL);
    upd_stb = 1; tick(1); upd_stb = 0;
    check("R3 active", cal_active, 1);
    check("R3 busy first edge", cal_busy, 0);
    tick(1);
    check("R3 busy second edge", cal_busy, 1);
    check("R8 hold during run", hold_sync, 1);
    wait_done();
    check("R5 active kept", cal_active, 1);
    check("R8 hold unlocked", hold_sync, 1);
    pll_lock = 1; tick(1);
    check("R8 hold released", hold_sync, 0);

    // R6: 1 over 1
    stage(1); commit(); tick(5);
    check("R6 no restart", cal_busy, 0);

    // R9: pause mid-run
    stage(0); commit(); check("R9 cleared", cal_active, 0);
    exp_q.push_back(CAL + 5);
    stage(1); commit(); tick(4);
    ref_present = 0; tick(5); ref_present = 1;
    wait_done();

    // R9: start waits for reference
    stage(0); commit(); ref_present = 0;
    stage(1); commit(); tick(6);
    check("R9 no start without ref", cal_busy, 0);
    exp_q.push_back(CAL);
    ref_present = 1; tick(1);
    check("R9 start on ref", cal_busy, 1);
    wait_done();

    // R11: rise during a run
    stage(0); commit();
    exp_q.push_back(CAL); exp_q.push_back(CAL);
    stage(1); commit(); tick(3);
    stage(0); commit(); stage(1); commit();
    check("R11 still busy", cal_busy, 1);
    while (!cal_done) tick(1);
    check("R11 gap", cal_busy, 0);
    tick(1);
    check("R11 relaunch", cal_busy, 1);
    wait_done();

    // R10: load-time restore
    load_busy = 1;
    load_wr = 1; load_bit = 0; tick(1);
    load_bit = 1; tick(1); load_wr = 0;
    check("R10 active loaded", cal_active, 1);
    tick(5);
    check("R10 held by load", cal_busy, 0);
    exp_q.push_back(CAL);
    load_busy = 0; tick(1);
    check("R10 starts after load", cal_busy, 1);
    wait_done();

    // R8: hold follows lock afterwards
    pll_lock = 0; tick(1);
    check("R8 hold on unlock", hold_sync, 1);
    pll_lock = 1; tick(1);
    check("R8 hold off on lock", hold_sync, 0);

    tick(3);
    check("R4 queue drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule